// File: doc/BRIEF.md
# PCI Self-Test Start Handshake Monitor

This block holds the built-in self-test byte of a PCI configuration header and runs the handshake between the remote configuration host and the local processor. The host starts a self-test by writing the start bit through configuration space. The block then raises a level interrupt to the local processor, provided the local side has enabled it. The local processor runs its own test and clears the start bit through its register port when the test passes. A deadline timer measures how long the start bit has been set. If the bit is still set after two seconds of clock cycles, it flags a failure, which is the outcome the host would report.

The controller is a three-state machine. Its states are IDLE (no test running), RUN (start bit set, timer counting) and LATE (start bit still set, deadline missed). Its transitions are:

- IDLE->RUN on a host start write.
- RUN->IDLE on a local done write, which is a pass.
- RUN->LATE when the timer expires without a done write.
- LATE->IDLE on a local done write.

A completion code of 0 marks a pass and a code of 1 marks a missed deadline.

Top module: `bist_start_monitor`

## Requirements
- R1: The configuration byte reads bit 7 = 1 (test capable), bit 6 = start bit, bits 5:4 = 0, and bits 3:0 = completion code.
- R2: A host start write with the local enable (local register 0, bit 0) set raises `irq` on the next cycle. With the enable clear, the start raises no interrupt, either then or later.
- R3: A configuration write with bit 6 = 1 while idle sets the start bit on the next cycle. The bit then stays set until the local side clears it.
- R4: `host_fail` asserts once the start bit has been set for LIMIT = CLK_HZ*DEADLINE_S cycles without a local clear. Once asserted, it stays high, and the start bit stays set, until a local clear.
- R5: A configuration write with bit 6 = 0 never clears the start bit. Any configuration write while the start bit is set changes nothing.
- R6: A local write to register 1 with bit 0 = 1 clears the start bit and `host_fail` on the next cycle. If that write lands in the cycle in which the deadline would expire, the clear wins and `host_fail` never asserts.
- R7: The completion code becomes 0 when a new test starts and stays 0 on a pass. It becomes 1 on a missed deadline and holds that value until the next start.
- R8: `irq` stays high until a local write to register 2 with bit 0 = 1. A new interrupt set in the same cycle as that write takes priority over the clear.
- R9: Local reads return the following values: register 0 = {7'b0, enable}, register 1 = {6'b0, host_fail, start}, register 2 = {7'b0, irq}, register 3 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe to the self-test byte |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Self-test byte as seen from configuration space |
| loc_wr | input | 1 | Local register write strobe |
| loc_addr | input | 2 | Local register select |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data for `loc_addr` |
| irq | output | 1 | Level interrupt to the local processor |
| host_fail | output | 1 | Deadline missed while the start bit was set |

## Verification
The bench places a local clear in exactly the cycle the deadline expires. A design that checked the timer before the clear would report a failure on a test that passed. It also starts a test with the interrupt disabled and enables it afterwards; a design that gated the interrupt at its output rather than at its set would then raise an interrupt late. Host writes that try to clear the start bit, and host restarts sent mid-test, would show up as an early clear, a restarted timer or a reset completion code. An interrupt acknowledge that lands in the same cycle as a new start checks the set-over-clear priority.

// File: rtl/bist_mon_pkg.sv
package bist_mon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LATE = 2'd2
    } bist_state_t;

    localparam logic [1:0] LOC_ENA  = 2'd0;
    localparam logic [1:0] LOC_DONE = 2'd1;
    localparam logic [1:0] LOC_ACK  = 2'd2;

    localparam logic [3:0] CODE_PASS = 4'h0;
    localparam logic [3:0] CODE_LATE = 4'h1;

    localparam int START_BIT = 6;
endpackage

// File: rtl/bist_deadline.sv
module bist_deadline #(
    parameter int unsigned LIMIT = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == LAST);

    // R4: the count advances by one on every cycle spent running.
    a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(expire)) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/bist_irq_latch.sv
module bist_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic ack,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (set_req) pend <= 1'b1;
        else if (ack)     pend <= 1'b0;
    end

    // R8: without an acknowledge, a pending interrupt stays pending.
    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);
endmodule

// File: rtl/bist_start_monitor.sv
module bist_start_monitor
    import bist_mon_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 125_000_000,
    parameter int unsigned DEADLINE_S = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       loc_wr,
    input  logic [1:0] loc_addr,
    input  logic [7:0] loc_wdata,
    output logic [7:0] loc_rdata,
    output logic       irq,
    output logic       host_fail
);
    localparam int unsigned LIMIT = CLK_HZ * DEADLINE_S;

    bist_state_t state_q, state_d;
    logic        enable_q;
    logic [3:0]  code_q;
    logic        host_start, done_wr, ack_wr, ena_wr;
    logic        expire, irq_set, start_bit;

    assign host_start = cfg_wr && cfg_wdata[START_BIT];
    assign done_wr    = loc_wr && (loc_addr == LOC_DONE) && loc_wdata[0];
    assign ack_wr     = loc_wr && (loc_addr == LOC_ACK) && loc_wdata[0];
    assign ena_wr     = loc_wr && (loc_addr == LOC_ENA);
    assign irq_set    = (state_q == ST_IDLE) && host_start && enable_q;

    bist_deadline #(.LIMIT(LIMIT)) u_deadline (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_RUN),
        .expire (expire)
    );

    bist_irq_latch u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (irq_set),
        .ack     (ack_wr),
        .pend    (irq)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (host_start) state_d = ST_RUN;
            ST_RUN: begin
                if (done_wr)     state_d = ST_IDLE;
                else if (expire) state_d = ST_LATE;
            end
            ST_LATE: if (done_wr) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            code_q   <= CODE_PASS;
        end else begin
            if (ena_wr) enable_q <= loc_wdata[0];
            if (state_q == ST_IDLE && host_start)
                code_q <= CODE_PASS;
            else if (state_q == ST_RUN && !done_wr && expire)
                code_q <= CODE_LATE;
        end
    end

    always_comb begin
        start_bit = (state_q != ST_IDLE);
        host_fail = (state_q == ST_LATE);
        cfg_rdata = {1'b1, start_bit, 2'b00, code_q};
        unique case (loc_addr)
            LOC_ENA:  loc_rdata = {7'b0, enable_q};
            LOC_DONE: loc_rdata = {6'b0, host_fail, start_bit};
            LOC_ACK:  loc_rdata = {7'b0, irq};
            default:  loc_rdata = 8'h00;
        endcase
    end

    // R3: the start bit only drops through a local done write.
    a_r3_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[6] && !done_wr) |=> cfg_rdata[6]);
    // R5: a host write that clears bit 6 leaves a set start bit alone.
    a_r5_host_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_wdata[6] && cfg_rdata[6] && !done_wr) |=> cfg_rdata[6]);
    // R2: an interrupt only rises if the enable was set.
    a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(enable_q));
    // R4: a failure is only reported while the start bit is still set.
    a_r4_fail_keeps_start: assert property (@(posedge clk) disable iff (!rst_n)
        host_fail |-> cfg_rdata[6]);
    // R7: a fresh start always shows the pass code.
    a_r7_code_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_rdata[6]) |-> (cfg_rdata[3:0] == CODE_PASS));
    // R6: a done write always ends the failure flag.
    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done_wr |=> (!host_fail && !cfg_rdata[6]));
endmodule

// File: tb/sim_bist_start_monitor.sv
module sim_bist_start_monitor;
    localparam int HZ  = 50;
    localparam int SEC = 2;
    localparam int LIM = HZ * SEC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       loc_wr = 1'b0;
    logic [1:0] loc_addr = 2'd0;
    logic [7:0] loc_wdata = 8'h00;
    logic [7:0] loc_rdata;
    logic       irq, host_fail;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // reference model state
    bit m_start, m_fail, m_en, m_pend;
    int m_code, m_cnt;

    always #4 clk = ~clk;

    bist_start_monitor #(.CLK_HZ(HZ), .DEADLINE_S(SEC)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .loc_wr(loc_wr), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .irq(irq),
        .host_fail(host_fail)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // behavioural model, updated at each edge from the stable inputs
    always @(posedge clk) begin
        bit old_en, lclr, ack, setp;
        cycles++;
        if (!rst_n) begin
            m_start = 0; m_fail = 0; m_en = 0; m_pend = 0; m_code = 0; m_cnt = 0;
        end else begin
            old_en = m_en;
            lclr = loc_wr && loc_addr == 2'd1 && loc_wdata[0];
            ack  = loc_wr && loc_addr == 2'd2 && loc_wdata[0];
            setp = 0;
            if (!m_start) begin
                if (cfg_wr && cfg_wdata[6]) begin
                    m_start = 1; m_cnt = 0; m_code = 0; setp = old_en;
                end
            end else if (!m_fail) begin
                if (lclr) m_start = 0;
                else if (m_cnt == LIM - 1) begin m_fail = 1; m_code = 1; end
                else m_cnt++;
            end else if (lclr) begin
                m_start = 0; m_fail = 0;
            end
            if (setp) m_pend = 1;
            else if (ack) m_pend = 0;
            if (loc_wr && loc_addr == 2'd0) m_en = loc_wdata[0];
        end
    end

    // compare every cycle, 2 ns after the edge
    always @(posedge clk) begin
        int exp_loc;
        #2;
        if (rst_n) begin
            unique case (loc_addr)
                2'd0: exp_loc = {7'b0, m_en};
                2'd1: exp_loc = {6'b0, m_fail, m_start};
                2'd2: exp_loc = {7'b0, m_pend};
                default: exp_loc = 0;
            endcase
            check("R1 capable bit", cfg_rdata[7], 1);
            check("R1 reserved bits", cfg_rdata[5:4], 0);
            check("R3 start bit", cfg_rdata[6], m_start);
            check("R7 completion code", cfg_rdata[3:0], m_code);
            check("R4 host_fail", host_fail, m_fail);
            check("R8 irq", irq, m_pend);
            check("R9 local read", loc_rdata, exp_loc);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_wr(input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0; cfg_wdata = 8'h00;
    endtask

    task automatic loc_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); loc_wr = 1'b1; loc_addr = a; loc_wdata = d;
        @(negedge clk); loc_wr = 1'b0; loc_wdata = 8'h00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset byte", cfg_rdata, 8'h80);
        check("R8 reset irq", irq, 0);

        // R2 + R3: enabled start, pass after a short test
        loc_write(2'd0, 8'h01);
        host_wr(8'h40);
        check("R2 irq raised", irq, 1);
        check("R3 start set", cfg_rdata[6], 1);
        // R5: host tries to clear, and to restart mid-test
        host_wr(8'h00);
        check("R5 host clear ignored", cfg_rdata[6], 1);
        host_wr(8'h40);
        idle(5);
        loc_addr = 2'd1;
        loc_write(2'd1, 8'h01);
        check("R6 local clear", cfg_rdata[6], 0);
        check("R7 pass code", cfg_rdata[3:0], 0);
        check("R8 irq held", irq, 1);
        loc_write(2'd2, 8'h01);
        check("R8 irq cleared", irq, 0);

        // R2: start with interrupts disabled, then enable
        loc_write(2'd0, 8'h00);
        host_wr(8'h40);
        loc_write(2'd0, 8'h01);
        loc_addr = 2'd2;
        idle(2);
        check("R2 no irq when disabled", irq, 0);

        // R4: let the deadline pass
        idle(LIM);
        check("R4 fail flagged", host_fail, 1);
        check("R7 late code", cfg_rdata[3:0], 1);
        host_wr(8'h00);
        check("R5 host clear during fail", cfg_rdata[6], 1);
        loc_write(2'd1, 8'h01);
        check("R6 clear from fail", host_fail, 0);
        check("R7 code kept after clear", cfg_rdata[3:0], 1);

        // R8: restart with ack in the same cycle as the new set
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 8'hC0;
        loc_wr = 1'b1; loc_addr = 2'd2; loc_wdata = 8'h01;
        @(negedge clk);
        cfg_wr = 1'b0; loc_wr = 1'b0;
        check("R8 set beats ack", irq, 1);
        check("R7 code reset on start", cfg_rdata[3:0], 0);

        // R6: clear lands exactly on the expiry cycle
        idle(LIM - 2);
        loc_write(2'd1, 8'h01);
        check("R6 clear wins at deadline", host_fail, 0);
        check("R6 start cleared at deadline", cfg_rdata[6], 0);
        idle(LIM + 5);
        check("R6 no late fail", host_fail, 0);

        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule